// File: doc/BRIEF.md
# Configuration Cycle Address Generator

This block turns a configuration request (bus, slot, function and register offset) into the two values a bridge needs to start a configuration cycle: a 24-bit address inside a 16 MB configuration window, and a 16-bit control word for the outbound window map register. It handles the two cycle types differently.

- **Bus 0, the local segment, type 0:** the device is chosen by a single one-hot select line. Low slots put that line in the upper address bits. Higher slots put it in the map word instead, because the address window is too narrow to hold it.
- **Any other bus, type 1:** bus, slot and function are packed as encoded fields.

A request is accepted on a valid/ready handshake. The result appears registered one cycle later and is held until the consumer takes it.

Control is a two-state machine:

- `ST_IDLE` drives `req_ready` high. Its transition `ACCEPT` (taken when `req_valid` is high) loads the result registers and moves to `ST_HOLD`.
- `ST_HOLD` drives `rsp_valid` high. It takes `STALL` back to itself while `rsp_ready` is low. It takes `RELEASE` back to `ST_IDLE` when `rsp_ready` is high.

Top module: `cfg_addr_gen`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1 and the result outputs are 0.
- R2: A request seen with `req_valid` and `req_ready` both high at a clock edge produces `rsp_valid` = 1 after that edge. `req_ready` is 0 for as long as `rsp_valid` is 1.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_addr`, `rsp_map` and `rsp_err` keep their values, and new requests have no effect. After an edge with `rsp_ready` high, `rsp_valid` is 0.
- R4: `rsp_map[3:1]` is always 3'b101, the configuration cycle code. `rsp_map[0]` is 0 when the bus is 0 (type 0, low address bits forced to zero) and 1 for any other bus (type 1, low address bits taken from the host).
- R5: For type 0, `rsp_addr[10:8]` holds the function and `rsp_addr[7:0]` holds the register offset.
- R6: For type 0 with slot 0 to 12, exactly one select bit is set, at address bit slot+11, and `rsp_map[15:4]` is zero.
- R7: For type 0 with slot 13 to 20, exactly one select bit is set, at map bit slot-5, and `rsp_addr[23:11]` is zero.
- R8: For type 0 with slot 21 to 31, `rsp_err` is 1 and no select bit is set in either `rsp_addr[23:11]` or `rsp_map[15:4]`.
- R9: For type 1, `rsp_addr[23:16]` is the bus, `[15:11]` the slot, `[10:8]` the function and `[7:0]` the offset. `rsp_map[15:4]` is zero.
- R10: `rsp_err` is 0 for every type-1 request and for every type-0 request with slot 20 or lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_bus | input | 8 | Target bus number |
| req_slot | input | 5 | Target device (slot) number |
| req_func | input | 3 | Target function number |
| req_offset | input | 8 | Configuration register byte offset |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 24 | Address within the 16 MB configuration window |
| rsp_map | output | 16 | Control word for the window map register |
| rsp_err | output | 1 | Slot cannot be selected on the local segment |

## Verification
If the state machine were stuck or skipped a state, the fault would show at the ports within one or two cycles. The result would be missing, `req_ready` and `rsp_valid` would both be high together, or a held result would change during a stall.

Faults in the select decode show in the first response for the affected slot. The symptoms are:

- a select bit at the wrong position, or in the wrong field;
- two select bits set at once;
- a select bit on an error slot.

Sweeping every slot and function on bus 0 and on several other buses therefore exposes any misplaced or doubled select bit in the same cycle that `rsp_valid` rises.

// File: rtl/cfgaddr_pkg.sv
package cfgaddr_pkg;
    localparam int BUS_W    = 8;
    localparam int SLOT_W   = 5;
    localparam int FUNC_W   = 3;
    localparam int OFF_W    = 8;
    localparam int ADDR_W   = 24;   // 16 MB window
    localparam int MAP_W    = 16;
    localparam int MAP_SEL_LSB = 8; // first map bit usable as select

    localparam int FUNC_LSB = OFF_W;
    localparam int SLOT_LSB = FUNC_LSB + FUNC_W;
    localparam int BUS_LSB  = SLOT_LSB + SLOT_W;
    localparam int SEL_BASE = SLOT_LSB;                         // address bit of slot 0
    localparam int LOW_MAX  = ADDR_W - 1 - SEL_BASE;            // last slot in address
    localparam int SLOT_MAX = LOW_MAX + (MAP_W - MAP_SEL_LSB);  // last selectable slot

    localparam logic [2:0] CYC_CONFIG = 3'b101;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [MAP_W-1:0]  map;
        logic              err;
    } cfg_result_t;
endpackage

// File: rtl/cfgaddr_type0.sv
module cfgaddr_type0
    import cfgaddr_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  offset,
    output cfg_result_t       res
);
    logic [ADDR_W-1:0] sel_addr;
    logic [MAP_W-1:0]  sel_map;

    // one-hot select in the address for low slots
    for (genvar i = 0; i < ADDR_W; i++) begin : g_asel
        if (i >= SEL_BASE) begin : g_on
            assign sel_addr[i] = (slot == SLOT_W'(i - SEL_BASE));
        end else begin : g_off
            assign sel_addr[i] = 1'b0;
        end
    end

    // one-hot select in the map word for high slots
    for (genvar j = 0; j < MAP_W; j++) begin : g_msel
        if (j >= MAP_SEL_LSB) begin : g_on
            assign sel_map[j] = (slot == SLOT_W'(LOW_MAX + 1 + j - MAP_SEL_LSB));
        end else begin : g_off
            assign sel_map[j] = 1'b0;
        end
    end

    always_comb begin
        res.addr = sel_addr;
        res.addr[SLOT_LSB-1:FUNC_LSB] = func;
        res.addr[OFF_W-1:0] = offset;
        res.map = sel_map;
        res.map[3:1] = CYC_CONFIG;
        res.map[0] = 1'b0;
        res.err = (slot > SLOT_W'(SLOT_MAX));
    end
endmodule

// File: rtl/cfgaddr_type1.sv
module cfgaddr_type1
    import cfgaddr_pkg::*;
(
    input  logic [BUS_W-1:0]  bus,
    input  logic [SLOT_W-1:0] slot,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  offset,
    output cfg_result_t       res
);
    always_comb begin
        res.addr = '0;
        res.addr[BUS_LSB+BUS_W-1:BUS_LSB] = bus;
        res.addr[SLOT_LSB+SLOT_W-1:SLOT_LSB] = slot;
        res.addr[SLOT_LSB-1:FUNC_LSB] = func;
        res.addr[OFF_W-1:0] = offset;
        res.map = '0;
        res.map[3:1] = CYC_CONFIG;
        res.map[0] = 1'b1;
        res.err = 1'b0;
    end
endmodule

// File: rtl/cfgaddr_ctrl.sv
module cfgaddr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_HOLD = 1'b1} state_t;
    state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_HOLD; // ACCEPT
            ST_HOLD: if (out_ready) state_nx = ST_IDLE; // RELEASE, else STALL
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid;
            end
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
    import cfgaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFF_W-1:0]  req_offset,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [MAP_W-1:0]  rsp_map,
    output logic              rsp_err
);
    cfg_result_t res_t0, res_t1, res_sel, res_q;
    logic load;

    cfgaddr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .out_ready(rsp_ready),
        .in_ready(req_ready), .out_valid(rsp_valid), .load(load)
    );

    cfgaddr_type0 u_t0 (
        .slot(req_slot), .func(req_func), .offset(req_offset), .res(res_t0)
    );

    cfgaddr_type1 u_t1 (
        .bus(req_bus), .slot(req_slot), .func(req_func), .offset(req_offset), .res(res_t1)
    );

    assign res_sel = (req_bus == '0) ? res_t0 : res_t1;

    always_ff @(posedge clk) begin
        if (!rst_n)    res_q <= '0;
        else if (load) res_q <= res_sel;
    end

    assign rsp_addr = res_q.addr;
    assign rsp_map  = res_q.map;
    assign rsp_err  = res_q.err;
endmodule

// File: rtl/cfgaddr_chk.sv
module cfgaddr_chk
    import cfgaddr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [MAP_W-1:0]  rsp_map,
    input logic              rsp_err
);
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_map) && $stable(rsp_err)));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> !rsp_valid);

    assert_cycle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_map[3:1] == CYC_CONFIG));

    assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_map[0] && !rsp_err) |->
            ($countones({rsp_addr[ADDR_W-1:SEL_BASE], rsp_map[MAP_W-1:4]}) == 1));

    assert_err_nosel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |->
            (!rsp_map[0] && $countones({rsp_addr[ADDR_W-1:SEL_BASE], rsp_map[MAP_W-1:4]}) == 0));

    assert_t1_nomapsel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_map[0]) |-> (rsp_map[MAP_W-1:4] == '0 && !rsp_err));
endmodule

bind cfg_addr_gen cfgaddr_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_map(rsp_map), .rsp_err(rsp_err)
);

// File: tb/tb_cfg_addr_gen.sv
module tb_cfg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_slot = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_offset = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [23:0] rsp_addr;
    logic [15:0] rsp_map;
    logic        rsp_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    cfg_addr_gen dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bus(req_bus), .req_slot(req_slot), .req_func(req_func), .req_offset(req_offset),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_map(rsp_map), .rsp_err(rsp_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input int bus, input int slot, input int func, input int off,
                                  output longint a, output longint m, output longint e);
        e = 0;
        if (bus == 0) begin
            a = func * 256 + off;
            m = 10;
            if (slot <= 12)      a = a + (longint'(1) << (slot + 11));
            else if (slot <= 20) m = m + (longint'(1) << (slot - 5));
            else                 e = 1;
        end else begin
            a = bus * 65536 + slot * 2048 + func * 256 + off;
            m = 11;
        end
    endfunction

    task automatic run_one(input int bus, input int slot, input int func, input int off);
        longint ea, em, ee;
        string tag;
        model(bus, slot, func, off, ea, em, ee);
        if (bus != 0)        tag = "R9";
        else if (slot <= 12) tag = "R6";
        else if (slot <= 20) tag = "R7";
        else                 tag = "R8";
        @(negedge clk);
        req_bus = bus[7:0]; req_slot = slot[4:0]; req_func = func[2:0]; req_offset = off[7:0];
        req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        check("R2 rsp_valid", rsp_valid, 1);
        check("R2 req_ready", req_ready, 0);
        check({tag, " addr"}, rsp_addr, ea);
        check("R4 map", rsp_map, em);
        check((ee != 0) ? "R8 err" : "R10 err", rsp_err, ee);
        if (bus == 0) check("R5 func/off", rsp_addr[10:0], func * 256 + off);
        req_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R3 release", rsp_valid, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 req_ready", req_ready, 1);
        check("R1 addr", rsp_addr, 0);
        check("R1 map", rsp_map, 0);
        rst_n = 1'b1;

        // Type 0: every slot and function, several offsets
        for (int s = 0; s < 32; s++)
            for (int f = 0; f < 8; f++)
                run_one(0, s, f, (s * 37 + f * 11) % 256);

        // Type 1: several buses, every slot
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 32; s++)
                run_one((b == 3) ? 255 : 1 + b * 70, s, s % 8, (s * 53 + b) % 256);

        // R3: stall with new requests offered, result must not move
        run_one(0, 3, 2, 8'h40);
        @(negedge clk);
        req_bus = 0; req_slot = 15; req_func = 5; req_offset = 8'h1c;
        req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_bus = 8'h22; req_slot = 1; req_func = 1; req_offset = 8'h04;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R3 hold valid", rsp_valid, 1);
            check("R3 hold addr", rsp_addr, 24'h000000 | (24'd5 << 8) | 24'h1c);
            check("R3 hold map", rsp_map, 16'h000a | (16'd1 << 10));
            check("R2 ready low", req_ready, 0);
        end
        req_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R3 released", rsp_valid, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule